// File: doc/BRIEF.md
# Banked CPU Memory Map Register File

This block holds the CPU-side address translation tables of a banked memory system. The processor's 64 KB space is cut into eight 8 KB slots. For each slot the block keeps a 16-bit physical bank number. There is a separate entry for every task and every tasklet within a task. Next to that table sits a small legacy map of 6-bit entries that belongs to the video side. A mode bit lets address lookups fall back to this legacy map, so software written for the older 512 KB scheme keeps working.

Software reaches the tables through a page of byte-wide registers. Five control registers set the mode, the task, the window view, the tasklet and a high-byte holding value. Eight slot registers form a window onto the entries of the current task and tasklet. A two-bit view selector decides what the window means, for reads and for writes. In the default view, a single byte write updates the legacy entry and the low byte of the wide entry together, and the high byte of the wide entry is loaded from the holding register. The lookup port is purely combinational: a 16-bit CPU address goes in, and a physical bank and a 29-bit physical address come out in the same cycle.

Top module: `mmu_bank_file`

## Requirements
- R1: After reset, the mode bit, task, view, tasklet and holding register are all zero. The read data output is zero. Every wide entry and every legacy entry holds its own slot number (identity map).
- R2: With the mode bit clear, `phys_bank` equals the wide entry selected by {task, tasklet, `cpu_addr[15:13]`}, and `phys_addr` is {`phys_bank`, `cpu_addr[12:0]`}. Both are valid in the same cycle as `cpu_addr`.
- R3: In view 0 (register 0x96 bits 1:0 = 00), a write to slot register 0xA0+s does three things: it stores data[5:0] in the legacy entry, stores the data in the low byte of the wide entry, and copies the holding register (0x9B) into the high byte of the wide entry. A read returns the low byte of the wide entry.
- R4: In view 1 (01), a slot read returns {2'b00, legacy entry}. A slot write changes only the legacy entry and leaves the wide entry unchanged.
- R5: In view 2 (10), a slot read returns wide entry bits 7:0. A slot write replaces only those bits.
- R6: In view 3 (11), a slot read returns wide entry bits 15:8. A slot write replaces only those bits.
- R7: Register 0x91 keeps 5 bits of task number and reads back with bits 7:5 as zero. Each task has its own set of wide entries.
- R8: Register 0x97 keeps and reads back all 8 bits. Only its low TASKLET_IDX_W bits (default 2) choose the tasklet, so tasklet values that agree in those bits share entries.
- R9: Register 0x90 bit 7 set selects emulation. Lookups then return the legacy entry, zero-extended, from the set chosen by task bit 0. Register 0x90 reads back with bits 6:0 as zero.
- R10: A read presents its data on `reg_rdata` one cycle after the strobe, and the value holds until the next read. Unassigned addresses read as zero. Writes to unassigned addresses, or writes with `reg_cs` low, change nothing.
- R11: Register 0x96 keeps only bits 1:0 and reads back with bits 7:2 as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_cs | input | 1 | Register page select |
| reg_addr | input | 8 | Register offset within the page |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cpu_addr | input | 16 | CPU logical address for lookup |
| phys_bank | output | 16 | Translated physical bank |
| phys_addr | output | 29 | Translated physical byte address |

## Verification
Register writes take effect at the clock edge that samples the strobe. The bench therefore drives every bus access on a falling edge and releases it one falling edge later, and each effect is observed from the cycle after that. Read data is due one edge after the read strobe, and the bench samples it on the falling edge that follows that edge. Lookup results are combinational, so each lookup is checked one time unit after `cpu_addr` changes, with the control state settled by earlier writes.

// File: rtl/mmu_bank_pkg.sv
package mmu_bank_pkg;

    localparam int SLOT_W  = 3;
    localparam int NSLOTS  = 1 << SLOT_W;
    localparam int ENTRY_W = 16;
    localparam int LEG_W   = 6;
    localparam int PAGE_W  = 13;
    localparam int PHYS_W  = ENTRY_W + PAGE_W;

    localparam logic [7:0] OFS_MODE    = 8'h90;
    localparam logic [7:0] OFS_TASK    = 8'h91;
    localparam logic [7:0] OFS_VIEW    = 8'h96;
    localparam logic [7:0] OFS_TASKLET = 8'h97;
    localparam logic [7:0] OFS_HOLD    = 8'h9B;
    localparam logic [4:0] WIN_TAG     = 5'b10100;

    typedef enum logic [1:0] {
        VIEW_DUAL   = 2'b00,
        VIEW_LEGACY = 2'b01,
        VIEW_LOW    = 2'b10,
        VIEW_HIGH   = 2'b11
    } view_e;

    typedef struct packed {
        logic       emul;
        logic [4:0] tsk;
        view_e      view;
        logic [7:0] tasklet;
        logic [7:0] hold;
    } ctrl_t;

endpackage

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
    import mmu_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            case (addr)
                OFS_MODE:    ctrl_d.emul    = wdata[7];
                OFS_TASK:    ctrl_d.tsk     = wdata[4:0];
                OFS_VIEW:    ctrl_d.view    = view_e'(wdata[1:0]);
                OFS_TASKLET: ctrl_d.tasklet = wdata;
                OFS_HOLD:    ctrl_d.hold    = wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{emul: 1'b0, tsk: '0, view: VIEW_DUAL, tasklet: '0, hold: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/mmu_cpu_map.sv
module mmu_cpu_map
    import mmu_bank_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         lo_data,
    input  logic [7:0]         hi_data,
    input  logic [IDX_W-1:0]   win_idx,
    output logic [ENTRY_W-1:0] win_entry,
    input  logic [IDX_W-1:0]   look_idx,
    output logic [ENTRY_W-1:0] look_entry
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] map_d [DEPTH];
    logic [ENTRY_W-1:0] map_q [DEPTH];

    always_comb begin
        map_d = map_q;
        if (wr_lo) begin
            map_d[wr_idx][7:0] = lo_data;
        end
        if (wr_hi) begin
            map_d[wr_idx][15:8] = hi_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                map_q[i] <= ENTRY_W'(i % NSLOTS);
            end
        end else begin
            map_q <= map_d;
        end
    end

    assign win_entry  = map_q[win_idx];
    assign look_entry = map_q[look_idx];

endmodule

// File: rtl/mmu_legacy_map.sv
module mmu_legacy_map
    import mmu_bank_pkg::*;
#(
    parameter int SET_W = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SET_W+SLOT_W-1:0] wr_idx,
    input  logic [LEG_W-1:0]        wr_data,
    input  logic [SET_W+SLOT_W-1:0] win_idx,
    output logic [LEG_W-1:0]        win_entry,
    input  logic [SET_W+SLOT_W-1:0] look_idx,
    output logic [LEG_W-1:0]        look_entry
);

    localparam int DEPTH = 1 << (SET_W + SLOT_W);

    logic [LEG_W-1:0] leg_d [DEPTH];
    logic [LEG_W-1:0] leg_q [DEPTH];

    always_comb begin
        leg_d = leg_q;
        if (wr_en) begin
            leg_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                leg_q[i] <= LEG_W'(i % NSLOTS);
            end
        end else begin
            leg_q <= leg_d;
        end
    end

    assign win_entry  = leg_q[win_idx];
    assign look_entry = leg_q[look_idx];

endmodule

// File: rtl/mmu_bank_file.sv
module mmu_bank_file
    import mmu_bank_pkg::*;
#(
    parameter int TASK_IDX_W    = 5,
    parameter int TASKLET_IDX_W = 2,
    parameter int LEG_SET_W     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_cs,
    input  logic [7:0]        reg_addr,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [15:0]       cpu_addr,
    output logic [ENTRY_W-1:0] phys_bank,
    output logic [PHYS_W-1:0] phys_addr
);

    localparam int IDX_W  = TASK_IDX_W + TASKLET_IDX_W + SLOT_W;
    localparam int LIDX_W = LEG_SET_W + SLOT_W;

    ctrl_t ctrl;
    logic [1:0] view_cur;
    logic       emul_cur;

    logic              win_hit;
    logic [SLOT_W-1:0] win_slot;
    logic [SLOT_W-1:0] look_slot;
    logic              win_wr;

    logic [IDX_W-1:0]  cpu_win_idx, cpu_look_idx;
    logic [LIDX_W-1:0] leg_win_idx, leg_look_idx;

    logic wr_lo, wr_hi, wr_leg;
    logic [7:0] hi_src;

    logic [ENTRY_W-1:0] cpu_win_entry, cpu_look_entry;
    logic [LEG_W-1:0]   leg_win_entry, leg_look_entry;

    logic [7:0] rd_d, rd_q;

    assign view_cur = ctrl.view;
    assign emul_cur = ctrl.emul;

    assign win_hit   = (reg_addr[7:3] == WIN_TAG);
    assign win_slot  = reg_addr[2:0];
    assign look_slot = cpu_addr[15:13];
    assign win_wr    = reg_cs && reg_we && win_hit;

    assign cpu_win_idx  = {ctrl.tsk[TASK_IDX_W-1:0], ctrl.tasklet[TASKLET_IDX_W-1:0], win_slot};
    assign cpu_look_idx = {ctrl.tsk[TASK_IDX_W-1:0], ctrl.tasklet[TASKLET_IDX_W-1:0], look_slot};
    assign leg_win_idx  = {ctrl.tsk[LEG_SET_W-1:0], win_slot};
    assign leg_look_idx = {ctrl.tsk[LEG_SET_W-1:0], look_slot};

    mmu_ctrl_regs i_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_cs && reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    always_comb begin
        wr_lo  = 1'b0;
        wr_hi  = 1'b0;
        wr_leg = 1'b0;
        hi_src = reg_wdata;
        if (win_wr) begin
            case (view_e'(view_cur))
                VIEW_DUAL: begin
                    wr_leg = 1'b1;
                    wr_lo  = 1'b1;
                    wr_hi  = 1'b1;
                    hi_src = ctrl.hold;
                end
                VIEW_LEGACY: wr_leg = 1'b1;
                VIEW_LOW:    wr_lo  = 1'b1;
                VIEW_HIGH:   wr_hi  = 1'b1;
                default:     ;
            endcase
        end
    end

    mmu_cpu_map #(.IDX_W(IDX_W)) i_cpu_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wr_idx     (cpu_win_idx),
        .lo_data    (reg_wdata),
        .hi_data    (hi_src),
        .win_idx    (cpu_win_idx),
        .win_entry  (cpu_win_entry),
        .look_idx   (cpu_look_idx),
        .look_entry (cpu_look_entry)
    );

    mmu_legacy_map #(.SET_W(LEG_SET_W)) i_leg_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_leg),
        .wr_idx     (leg_win_idx),
        .wr_data    (reg_wdata[LEG_W-1:0]),
        .win_idx    (leg_win_idx),
        .win_entry  (leg_win_entry),
        .look_idx   (leg_look_idx),
        .look_entry (leg_look_entry)
    );

    // lookup path
    always_comb begin
        if (emul_cur) begin
            phys_bank = {{(ENTRY_W-LEG_W){1'b0}}, leg_look_entry};
        end else begin
            phys_bank = cpu_look_entry;
        end
    end
    assign phys_addr = {phys_bank, cpu_addr[PAGE_W-1:0]};

    // register read path
    always_comb begin
        rd_d = rd_q;
        if (reg_cs && reg_re) begin
            rd_d = '0;
            if (win_hit) begin
                case (view_e'(view_cur))
                    VIEW_DUAL:   rd_d = cpu_win_entry[7:0];
                    VIEW_LEGACY: rd_d = {2'b00, leg_win_entry};
                    VIEW_LOW:    rd_d = cpu_win_entry[7:0];
                    VIEW_HIGH:   rd_d = cpu_win_entry[15:8];
                    default:     rd_d = '0;
                endcase
            end else begin
                case (reg_addr)
                    OFS_MODE:    rd_d = {emul_cur, 7'b0};
                    OFS_TASK:    rd_d = {3'b000, ctrl.tsk};
                    OFS_VIEW:    rd_d = {6'b0, view_cur};
                    OFS_TASKLET: rd_d = ctrl.tasklet;
                    OFS_HOLD:    rd_d = ctrl.hold;
                    default:     rd_d = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign reg_rdata = rd_q;

endmodule

// File: rtl/mmu_bank_file_chk.sv
module mmu_bank_file_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_cs,
    input logic [7:0]  reg_addr,
    input logic        reg_we,
    input logic        reg_re,
    input logic [7:0]  reg_rdata,
    input logic [15:0] cpu_addr,
    input logic [15:0] phys_bank,
    input logic [1:0]  view,
    input logic        emul
);

    // R10: read data is held between reads
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_cs && reg_re) |=> $stable(reg_rdata));

    // R10: an unassigned offset reads zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_cs && reg_re && reg_addr == 8'h92) |=> (reg_rdata == 8'h00));

    // R7: the task register reads back with bits 7:5 clear
    a_r7_task_width: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_cs && reg_re && reg_addr == 8'h91) |=> (reg_rdata[7:5] == 3'b000));

    // R9: the mode register reads back with bits 6:0 clear
    a_r9_mode_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_cs && reg_re && reg_addr == 8'h90) |=> (reg_rdata[6:0] == 7'b0));

    // R9: emulation lookups stay inside the 6-bit bank range
    a_r9_emul_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        emul |-> (phys_bank[15:6] == 10'b0));

    // R4: a legacy-view window read carries a 6-bit value
    a_r4_legacy_read: assert property (@(posedge clk) disable iff (!rst_n)
        (view == 2'b01 && reg_cs && reg_re && reg_addr[7:3] == 5'b10100)
        |=> (reg_rdata[7:6] == 2'b00));

    // R2: without a write, a steady address gives a steady bank
    a_r2_lookup_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> (!$stable(cpu_addr) || $stable(phys_bank)));

endmodule

bind mmu_bank_file mmu_bank_file_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_cs    (reg_cs),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata),
    .cpu_addr  (cpu_addr),
    .phys_bank (phys_bank),
    .view      (view_cur),
    .emul      (emul_cur)
);

// File: tb/test_mmu_bank_file.sv
module test_mmu_bank_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_cs = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr = '0;
    logic [15:0] phys_bank;
    logic [28:0] phys_addr;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mmu_bank_file i_mmu_bank_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_cs    (reg_cs),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cpu_addr  (cpu_addr),
        .phys_bank (phys_bank),
        .phys_addr (phys_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic cs = 1'b1);
        @(negedge clk);
        reg_cs = cs; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_cs = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_cs = 1'b1; reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_cs = 1'b0; reg_re = 1'b0;
        chk(tag, {24'b0, reg_rdata}, {24'b0, exp});
    endtask

    task automatic look_chk(input string tag, input logic [15:0] a, input logic [15:0] bank);
        @(negedge clk);
        cpu_addr = a;
        #1;
        chk({tag, " bank"}, {16'b0, phys_bank}, {16'b0, bank});
        chk({tag, " addr"}, {3'b0, phys_addr}, {3'b0, bank, a[12:0]});
    endtask

    task automatic home();
        wr(8'h90, 8'h00); wr(8'h91, 8'h00); wr(8'h97, 8'h00); wr(8'h96, 8'h00);
    endtask

    task automatic t_reset();
        chk("R1 rdata at reset", {24'b0, reg_rdata}, 32'h0);
        rd_chk("R1 mode", 8'h90, 8'h00);
        rd_chk("R1 task", 8'h91, 8'h00);
        rd_chk("R1 view", 8'h96, 8'h00);
        rd_chk("R1 tasklet", 8'h97, 8'h00);
        rd_chk("R1 hold", 8'h9B, 8'h00);
        for (int s = 0; s < 8; s++) begin
            look_chk("R1 R2 identity", {s[2:0], 13'h0ABC}, 16'(s));
            rd_chk("R1 window identity", 8'hA0 + 8'(s), 8'(s));
        end
        wr(8'h96, 8'h01);
        rd_chk("R1 legacy identity", 8'hA6, 8'h06);
        wr(8'h96, 8'h00);
    endtask

    task automatic t_dual();
        home();
        wr(8'h9B, 8'h12);
        wr(8'hA3, 8'hC5);
        look_chk("R3 R2 dual write", 16'h6123, 16'h12C5);
        rd_chk("R3 dual read low", 8'hA3, 8'hC5);
        wr(8'h96, 8'h01);
        rd_chk("R3 legacy got low 6", 8'hA3, 8'h05);
        wr(8'h96, 8'h03);
        rd_chk("R3 high from hold", 8'hA3, 8'h12);
    endtask

    task automatic t_legacy();
        home();
        wr(8'h96, 8'h01);
        wr(8'hA4, 8'hEA);
        rd_chk("R4 legacy read", 8'hA4, 8'h2A);
        look_chk("R4 wide untouched", 16'h8000, 16'h0004);
        wr(8'h90, 8'h80);
        rd_chk("R9 mode readback", 8'h90, 8'h80);
        look_chk("R9 emul slot4", 16'h8123, 16'h002A);
        look_chk("R9 emul slot3", 16'h7FFF, 16'h0005);
        wr(8'h90, 8'h00);
        look_chk("R9 native again", 16'h8000, 16'h0004);
    endtask

    task automatic t_bytes();
        home();
        wr(8'h96, 8'h02);
        wr(8'hA5, 8'h77);
        look_chk("R5 low only", 16'hA000, 16'h0077);
        rd_chk("R5 low read", 8'hA5, 8'h77);
        wr(8'h96, 8'h03);
        wr(8'hA5, 8'hAB);
        look_chk("R6 high only", 16'hBFFF, 16'hAB77);
        rd_chk("R6 high read", 8'hA5, 8'hAB);
        wr(8'h96, 8'h01);
        rd_chk("R5 R6 legacy untouched", 8'hA5, 8'h05);
    endtask

    task automatic t_tasks();
        home();
        wr(8'h91, 8'hFF);
        rd_chk("R7 task 5 bits", 8'h91, 8'h1F);
        look_chk("R7 task31 identity", 16'h4000, 16'h0002);
        wr(8'h96, 8'h02);
        wr(8'hA2, 8'h99);
        look_chk("R7 task31 write", 16'h4000, 16'h0099);
        wr(8'h90, 8'h80);
        look_chk("R9 set1 slot4", 16'h8000, 16'h0004);
        wr(8'h90, 8'h00);
        wr(8'h91, 8'h00);
        look_chk("R7 task0 separate", 16'h4000, 16'h0002);
    endtask

    task automatic t_tasklets();
        home();
        wr(8'h97, 8'hA5);
        rd_chk("R8 tasklet 8 bits", 8'h97, 8'hA5);
        look_chk("R8 tasklet1 identity", 16'hE000, 16'h0007);
        wr(8'h96, 8'h02);
        wr(8'hA7, 8'h3C);
        look_chk("R8 tasklet1 write", 16'hE000, 16'h003C);
        wr(8'h97, 8'h00);
        look_chk("R8 tasklet0 separate", 16'hE000, 16'h0007);
        wr(8'h97, 8'h05);
        look_chk("R8 alias low bits", 16'hE000, 16'h003C);
    endtask

    task automatic t_misc();
        home();
        rd_chk("R10 unmapped read", 8'h92, 8'h00);
        wr(8'h91, 8'h03);
        wr(8'h92, 8'h1A);
        rd_chk("R10 unmapped write no effect", 8'h91, 8'h03);
        repeat (3) @(negedge clk);
        chk("R10 rdata held", {24'b0, reg_rdata}, 32'h03);
        wr(8'h91, 8'h00);
        wr(8'hA1, 8'hEE, 1'b0);
        look_chk("R10 cs low no write", 16'h2000, 16'h0001);
        wr(8'h96, 8'hFE);
        rd_chk("R11 view 2 bits", 8'h96, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dual();
        t_legacy();
        t_bytes();
        t_tasks();
        t_tasklets();
        t_misc();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 50000);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule